// File: doc/BRIEF.md
# Per-Class Active Object Access Monitor

This block watches a stream of field-access events. Each event names a class, an object of that class, an access category and the size of that object in words. For every class the block remembers which object is currently active, and it keeps a *frame* for that object. A frame holds one access counter per category and the number of cycle ticks seen while the object stays active. When an access arrives for a different object of the same class, the frame closes. The new object then becomes active, and its frame opens with that access already counted.

Each closed frame leaves the block as one record on a valid/ready stream. The record carries the class, the object, the four category counts and the duration. It also carries an estimate of the cycles that caching the object would have saved. This estimate is the per-category savings weighted by the counts, minus one cycle for each word that must be moved into the cache. A flush input closes every open frame, one class at a time in ascending order, so that the frames still running at the end of a measurement are reported too.

Top module: `access_frame_monitor`

## Requirements
- R1: After reset, `rec_valid` is 0, `ev_ready` is 1 and every class slot is empty.
- R2: An accepted event for a class with no open frame opens a frame for `ev_obj` and emits no record.
- R3: Each accepted event for the active object of its class adds one to that frame's counter for category `ev_cat`. The encodings are 0 narrow field, 1 wide field, 2 narrow element and 3 wide element.
- R4: An accepted event whose object differs from the active object of its class emits one record for the old frame. The record carries the old object and the class. The event's object becomes active, with a new frame whose counts are zero except one in `ev_cat`.
- R5: A record's duration counts the clock edges that had `tick` high after the edge that opened the frame, up to but not including the edge that closed it.
- R6: The savings of a record are 2·c0 + 3·c1 + 3·c2 + 4·c3, where ck is the count of category k. `rec_gain` is the savings minus the size captured at the frame's opening event.
- R7: When the size exceeds the savings, `rec_gain` is 0 and `rec_loss` is 1. When the size is equal to or below the savings, `rec_loss` is 0.
- R8: Frames of different classes are independent. Events for one class never change another class's frame.
- R9: While a record is pending and `rec_ready` is low, an event that would close a frame is held (`ev_ready` low). Events that close nothing are still accepted.
- R10: While `rec_valid` is high and `rec_ready` is low, every record field stays unchanged.
- R11: A `flush` pulse closes all open frames in ascending class order and skips empty slots. It emits one record per open frame. `ev_ready` stays low until the scan ends, and all slots are empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Cycle tick counted into every open frame |
| ev_valid | input | 1 | Access event present |
| ev_ready | output | 1 | Event accepted on this edge when high with `ev_valid` |
| ev_class | input | CLS_W | Class slot of the access |
| ev_obj | input | OBJ_W | Object identifier |
| ev_cat | input | 2 | Access category (0..3) |
| ev_size | input | SIZE_W | Object size in words |
| flush | input | 1 | Start closing all open frames |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_class | output | CLS_W | Class of the closed frame |
| rec_obj | output | OBJ_W | Object of the closed frame |
| rec_cnt | output | 4·CNT_W | Category counts, category k at bits [k·CNT_W +: CNT_W] |
| rec_dur | output | DUR_W | Frame duration in ticks |
| rec_gain | output | CNT_W+4 | Net cycles gained, floored at zero |
| rec_loss | output | 1 | Transfer cost exceeded the savings |

## Verification
The sweep walks every class through frames with zero to two extra accesses per category and sizes of 0, 7 and 20 words. This reaches the point where the gain is exactly zero without a loss, as well as true losses. A design with a wrong weight or a gain that wraps would show odd values there. A second scenario drains a pending record slowly. A design that overwrote the held record, or accepted a closing event into a full buffer, would lose or corrupt a frame. Flush runs with one empty slot and a toggling `rec_ready`, so a design that emitted empty slots, scanned out of order or left slots open would produce extra records or records out of order.

// File: rtl/afm_pkg.sv
// Shared definitions for the access frame monitor.
// Assumes exactly four access categories with fixed per-access savings.
package afm_pkg;
    localparam int unsigned NUM_CATS = 4;

    typedef enum logic [1:0] {
        CAT_NARROW_FIELD = 2'd0,
        CAT_WIDE_FIELD   = 2'd1,
        CAT_NARROW_ELEM  = 2'd2,
        CAT_WIDE_ELEM    = 2'd3
    } acc_cat_e;

    // Cycles saved per access of category k when the object is cached.
    function automatic int unsigned cat_saving(input int unsigned k);
        case (k)
            0:       return 2;
            1:       return 3;
            2:       return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/afm_slot.sv
// One class slot: holds the active object, its size, the category counters
// and the tick-based duration of the open frame.
// Assumes open, hit and clear are mutually exclusive; counters saturate.
module afm_slot #(
    parameter int OBJ_W  = 8,
    parameter int SIZE_W = 8,
    parameter int CNT_W  = 16,
    parameter int DUR_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          open,
    input  logic                          hit,
    input  logic                          clear,
    input  logic [OBJ_W-1:0]              new_obj,
    input  logic [SIZE_W-1:0]             new_size,
    input  logic [1:0]                    cat,
    output logic                          valid,
    output logic [OBJ_W-1:0]              obj,
    output logic [SIZE_W-1:0]             size,
    output logic [afm_pkg::NUM_CATS*CNT_W-1:0] cnt,
    output logic [DUR_W-1:0]              dur
);
    import afm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [DUR_W-1:0] DUR_MAX = '1;

    // Frame state: open a fresh frame, clear on flush, or count accesses/ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            obj   <= '0;
            size  <= '0;
            cnt   <= '0;
            dur   <= '0;
        end else if (open) begin
            valid <= 1'b1;
            obj   <= new_obj;
            size  <= new_size;
            dur   <= '0;
            for (int k = 0; k < NUM_CATS; k++)
                cnt[k*CNT_W +: CNT_W] <= CNT_W'(cat == 2'(k));
        end else if (clear) begin
            valid <= 1'b0;
        end else begin
            if (hit) begin
                for (int k = 0; k < NUM_CATS; k++)
                    if (cat == 2'(k) && cnt[k*CNT_W +: CNT_W] != CNT_MAX)
                        cnt[k*CNT_W +: CNT_W] <= cnt[k*CNT_W +: CNT_W] + 1'b1;
            end
            if (tick && valid && dur != DUR_MAX)
                dur <= dur + 1'b1;
        end
    end

    // R2: an opening event leaves a live frame with zero duration.
    a_r2_open_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        open |=> (valid && dur == '0));

    // R3: counting hits only ever target a slot that already holds a frame.
    a_r3_hit_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> valid);

    // R5: a tick on an undisturbed open frame advances its duration by one.
    a_r5_dur_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && tick && !open && !clear && dur != DUR_MAX) |=> (dur == $past(dur) + 1'b1));
endmodule

// File: rtl/afm_gain.sv
// Net gain estimate for one frame: weighted category savings minus one
// cycle per object word, floored at zero with a loss flag.
// Assumes GAIN_W is wide enough for 4 * max count * 4 and for the size.
module afm_gain #(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 8,
    parameter int GAIN_W = CNT_W + 4
) (
    input  logic [afm_pkg::NUM_CATS*CNT_W-1:0] cnt,
    input  logic [SIZE_W-1:0]                  size,
    output logic [GAIN_W-1:0]                  gain,
    output logic                               loss
);
    import afm_pkg::*;

    logic [GAIN_W-1:0] savings;
    logic [GAIN_W-1:0] cost;

    // Weighted sum of the category counters.
    always_comb begin
        savings = '0;
        for (int k = 0; k < NUM_CATS; k++)
            savings = savings + GAIN_W'(cnt[k*CNT_W +: CNT_W]) * GAIN_W'(cat_saving(k));
    end

    // Subtract transfer cost, clamp at zero.
    always_comb begin
        cost = GAIN_W'(size);
        loss = cost > savings;
        gain = loss ? '0 : savings - cost;
    end
endmodule

// File: rtl/access_frame_monitor.sv
// Per-class active object access monitor. Keeps one open frame per class
// slot, closes it when another object of that class is accessed or on flush,
// and presents each closed frame as a record on a one-entry valid/ready
// output register.
// Assumes ev_class < NUM_CLASSES; events are not taken during a flush scan.
module access_frame_monitor #(
    parameter  int NUM_CLASSES = 4,
    parameter  int OBJ_W       = 8,
    parameter  int SIZE_W      = 8,
    parameter  int CNT_W       = 16,
    parameter  int DUR_W       = 16,
    localparam int CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    localparam int GAIN_W      = CNT_W + 4,
    localparam int CNTS_W      = afm_pkg::NUM_CATS * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [CLS_W-1:0]  ev_class,
    input  logic [OBJ_W-1:0]  ev_obj,
    input  logic [1:0]        ev_cat,
    input  logic [SIZE_W-1:0] ev_size,
    input  logic              flush,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [CLS_W-1:0]  rec_class,
    output logic [OBJ_W-1:0]  rec_obj,
    output logic [CNTS_W-1:0] rec_cnt,
    output logic [DUR_W-1:0]  rec_dur,
    output logic [GAIN_W-1:0] rec_gain,
    output logic              rec_loss
);
    localparam logic [CLS_W-1:0] LAST_CLASS = CLS_W'(NUM_CLASSES - 1);

    logic [NUM_CLASSES-1:0] s_valid;
    logic [OBJ_W-1:0]       s_obj  [NUM_CLASSES];
    logic [SIZE_W-1:0]      s_size [NUM_CLASSES];
    logic [CNTS_W-1:0]      s_cnt  [NUM_CLASSES];
    logic [DUR_W-1:0]       s_dur  [NUM_CLASSES];

    logic             flush_act;
    logic [CLS_W-1:0] scan_idx;
    logic             ev_close, buf_free, ev_fire, fl_close, fl_adv, load;
    logic [CLS_W-1:0] sel;
    logic [GAIN_W-1:0] g_gain;
    logic             g_loss;

    // Event admission, flush progress and record-load decisions.
    always_comb begin
        ev_close = s_valid[ev_class] && (s_obj[ev_class] != ev_obj);
        buf_free = !rec_valid || rec_ready;
        ev_ready = !flush_act && (!ev_close || buf_free);
        ev_fire  = ev_valid && ev_ready;
        fl_close = flush_act && s_valid[scan_idx] && buf_free;
        fl_adv   = flush_act && (!s_valid[scan_idx] || buf_free);
        load     = (ev_fire && ev_close) || fl_close;
        sel      = flush_act ? scan_idx : ev_class;
    end

    // One slot per class; the selected slot is the only one an event touches.
    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_slot
        logic mine, same;
        always_comb begin
            mine = ev_fire && (ev_class == CLS_W'(i));
            same = s_valid[i] && (s_obj[i] == ev_obj);
        end
        afm_slot #(
            .OBJ_W(OBJ_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .DUR_W(DUR_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .open     (mine && !same),
            .hit      (mine && same),
            .clear    (fl_close && (scan_idx == CLS_W'(i))),
            .new_obj  (ev_obj),
            .new_size (ev_size),
            .cat      (ev_cat),
            .valid    (s_valid[i]),
            .obj      (s_obj[i]),
            .size     (s_size[i]),
            .cnt      (s_cnt[i]),
            .dur      (s_dur[i])
        );
    end

    afm_gain #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .GAIN_W(GAIN_W)) u_gain (
        .cnt  (s_cnt[sel]),
        .size (s_size[sel]),
        .gain (g_gain),
        .loss (g_loss)
    );

    // Output record register: load a closing frame, or drain on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_class <= '0;
            rec_obj   <= '0;
            rec_cnt   <= '0;
            rec_dur   <= '0;
            rec_gain  <= '0;
            rec_loss  <= 1'b0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_class <= sel;
            rec_obj   <= s_obj[sel];
            rec_cnt   <= s_cnt[sel];
            rec_dur   <= s_dur[sel];
            rec_gain  <= g_gain;
            rec_loss  <= g_loss;
        end else if (rec_ready) begin
            rec_valid <= 1'b0;
        end
    end

    // Flush scan: walk slots in ascending order, wait on a busy output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_act <= 1'b0;
            scan_idx  <= '0;
        end else if (!flush_act) begin
            if (flush) begin
                flush_act <= 1'b1;
                scan_idx  <= '0;
            end
        end else if (fl_adv) begin
            if (scan_idx == LAST_CLASS) begin
                flush_act <= 1'b0;
                scan_idx  <= '0;
            end else begin
                scan_idx <= scan_idx + 1'b1;
            end
        end
    end

    // R4: a closing event yields a record for that class on the next edge.
    a_r4_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_close) |=> (rec_valid && rec_class == $past(ev_class)));

    // R7: a loss record never reports a positive gain.
    a_r7_loss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_loss) |-> (rec_gain == '0));

    // R9: a closing event is refused while the record cannot drain.
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_close && rec_valid && !rec_ready) |-> !ev_ready);

    // R10: a stalled record holds every field.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_class) && $stable(rec_obj)
            && $stable(rec_cnt) && $stable(rec_dur) && $stable(rec_gain) && $stable(rec_loss)));

    // R11: no event is admitted while the flush scan runs.
    a_r11_quiet_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_act |-> !ev_ready);
endmodule

// File: tb/sim_access_frame_monitor.sv
module sim_access_frame_monitor;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic ev_valid = 1'b0;
    logic [1:0] ev_class = '0;
    logic [7:0] ev_obj = '0;
    logic [1:0] ev_cat = '0;
    logic [7:0] ev_size = '0;
    logic flush = 1'b0;
    logic rec_ready = 1'b1;
    logic ev_ready, rec_valid, rec_loss;
    logic [1:0] rec_class;
    logic [7:0] rec_obj;
    logic [63:0] rec_cnt;
    logic [15:0] rec_dur;
    logic [19:0] rec_gain;

    always #2 clk = ~clk;

    access_frame_monitor u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_class(ev_class),
        .ev_obj(ev_obj), .ev_cat(ev_cat), .ev_size(ev_size), .flush(flush),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_class(rec_class),
        .rec_obj(rec_obj), .rec_cnt(rec_cnt), .rec_dur(rec_dur),
        .rec_gain(rec_gain), .rec_loss(rec_loss)
    );

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // reference model state
    bit m_valid [NC];
    int m_obj [NC];
    int m_size [NC];
    int m_dur [NC];
    int m_cnt [NC][4];
    bit m_full = 0;
    int b_cls, b_obj, b_size, b_dur;
    int b_cnt [4];
    bit m_flush = 0;
    int m_idx = 0;
    bit last_fire = 0;
    int n_recs = 0;
    int cyc = 0;

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_eval();
        bit rdy, close, bfree, flc, fladv, fire;
        int c, sav, eg, el;
        c = int'(ev_class);
        close = m_valid[c] && (m_obj[c] != int'(ev_obj));
        bfree = !m_full || rec_ready;
        rdy = !m_flush && (!close || bfree);
        chk("ev_ready", int'(ev_ready), int'(rdy));
        chk("rec_valid", int'(rec_valid), int'(m_full));
        if (m_full) begin
            sav = 2*b_cnt[0] + 3*b_cnt[1] + 3*b_cnt[2] + 4*b_cnt[3];
            el = (b_size > sav) ? 1 : 0;
            eg = el ? 0 : sav - b_size;
            chk("rec_class", int'(rec_class), b_cls);
            chk("rec_obj", int'(rec_obj), b_obj);
            for (int k = 0; k < 4; k++)
                chk("rec_cnt", int'(rec_cnt[k*16 +: 16]), b_cnt[k]);
            chk("rec_dur", int'(rec_dur), b_dur);
            chk("rec_gain", int'(rec_gain), eg);
            chk("rec_loss", int'(rec_loss), el);
            if (rec_ready) n_recs++;
        end
        fire = ev_valid && rdy;
        last_fire = fire;
        flc = m_flush && m_valid[m_idx] && bfree;
        fladv = m_flush && (!m_valid[m_idx] || bfree);
        // record register
        if ((fire && close) || flc) begin
            int s;
            s = flc ? m_idx : c;
            m_full = 1; b_cls = s; b_obj = m_obj[s]; b_size = m_size[s]; b_dur = m_dur[s];
            for (int k = 0; k < 4; k++) b_cnt[k] = m_cnt[s][k];
        end else if (rec_ready) begin
            m_full = 0;
        end
        // slots
        for (int i = 0; i < NC; i++) begin
            if (fire && c == i) begin
                if (!m_valid[i] || close) begin
                    m_valid[i] = 1; m_obj[i] = int'(ev_obj); m_size[i] = int'(ev_size); m_dur[i] = 0;
                    for (int k = 0; k < 4; k++) m_cnt[i][k] = (k == int'(ev_cat)) ? 1 : 0;
                end else begin
                    m_cnt[i][ev_cat]++;
                    if (tick) m_dur[i]++;
                end
            end else if (flc && m_idx == i) begin
                m_valid[i] = 0;
            end else if (tick && m_valid[i]) begin
                m_dur[i]++;
            end
        end
        // flush scan
        if (!m_flush) begin
            if (flush) begin m_flush = 1; m_idx = 0; end
        end else if (fladv) begin
            if (m_idx == NC-1) m_flush = 0;
            m_idx = (m_idx + 1) % NC;
        end
    endtask

    // one clock: evaluate just before the edge, return at next falling edge
    task automatic step();
        #1;
        model_eval();
        @(negedge clk);
        cyc++;
        tick = (cyc % 3) != 0;
    endtask

    task automatic send_ev(int cls, int obj, int cat, int size);
        ev_valid = 1; ev_class = 2'(cls); ev_obj = 8'(obj); ev_cat = 2'(cat); ev_size = 8'(size);
        do step(); while (!last_fire);
        ev_valid = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        step();
        flush = 0;
        while (m_flush || m_full) begin
            rec_ready = ~rec_ready;
            step();
        end
        rec_ready = 1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            m_valid[i] = 0; m_obj[i] = 0; m_size[i] = 0; m_dur[i] = 0;
            for (int k = 0; k < 4; k++) m_cnt[i][k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        cur_req = "R1";
        chk("reset rec_valid", int'(rec_valid), 0);
        chk("reset ev_ready", int'(ev_ready), 1);
        @(negedge clk);

        // R2/R3: open and count each category
        cur_req = "R2";
        send_ev(0, 5, 0, 3);
        chk("no record on open", int'(rec_valid), 0);
        cur_req = "R3";
        send_ev(0, 5, 1, 9);
        send_ev(0, 5, 2, 9);
        send_ev(0, 5, 3, 9);
        send_ev(0, 5, 3, 9);
        repeat (3) step();
        // R4/R5/R6: close by a new object
        cur_req = "R4";
        send_ev(0, 6, 1, 2);
        cur_req = "R5";
        repeat (2) step();

        // R7: loss and exact break-even
        cur_req = "R7";
        send_ev(1, 1, 0, 20);
        send_ev(1, 2, 0, 1);
        send_ev(2, 3, 3, 4);
        send_ev(2, 4, 0, 0);
        repeat (2) step();

        // R8: interleaved classes
        cur_req = "R8";
        send_ev(3, 7, 2, 5);
        send_ev(1, 2, 1, 1);
        send_ev(3, 7, 0, 5);
        send_ev(1, 2, 2, 1);
        send_ev(3, 8, 1, 6);
        send_ev(1, 9, 3, 6);
        repeat (2) step();

        // R9/R10: closing event stalls behind an unread record
        cur_req = "R9";
        rec_ready = 0;
        send_ev(0, 10, 0, 2);
        send_ev(3, 8, 3, 6);
        ev_valid = 1; ev_class = 2'd3; ev_obj = 8'd11; ev_cat = 2'd1; ev_size = 8'd3;
        cur_req = "R10";
        repeat (4) step();
        cur_req = "R9";
        rec_ready = 1;
        do step(); while (!last_fire);
        ev_valid = 0;
        repeat (2) step();

        // R11: flush with slot 2 empty after flushing once
        cur_req = "R11";
        do_flush();
        send_ev(0, 10, 2, 1);
        send_ev(3, 12, 0, 2);
        send_ev(1, 13, 3, 0);
        n_recs = 0;
        do_flush();
        chk("flush record count", n_recs, 3);
        send_ev(0, 10, 1, 1);
        step();
        chk("slot empty after flush", int'(rec_valid), 0);
        do_flush();

        // R6 sweep: counts 0..2 per category, three sizes, all classes
        cur_req = "R6";
        for (int cls = 0; cls < NC; cls++)
            for (int si = 0; si < 3; si++)
                for (int combo = 0; combo < 81; combo++) begin
                    int sz, ob, n;
                    sz = (si == 0) ? 0 : (si == 1) ? 7 : 20;
                    ob = 32 + cls * 4 + (combo % 2);
                    send_ev(cls, ob, 0, sz);
                    n = combo;
                    for (int k = 0; k < 4; k++) begin
                        for (int r = 0; r < n % 3; r++) send_ev(cls, ob, k, sz);
                        n = n / 3;
                    end
                end
        do_flush();
        repeat (2) step();
        summary();
    end
endmodule